// File: doc/BRIEF.md
# Load/Store Byte Lane Aligner

This block sits between a 32-bit core and a data memory that is organised in whole words. For a store it turns the access size, the two low address bits and the source register value into a per-byte write enable and a write word whose bytes already sit in the lanes the memory will update. For a load it takes the full word read from memory, picks the byte, halfword or word that the address points at, and widens it to 32 bits with either sign or zero fill, as the load's function code asks. Misaligned-access traps and the memory array itself are outside the block.

Each access enters as one request on a valid/ready port and leaves as one result on a valid/ready port, one register stage later. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the result register is empty or its content is being taken in the same cycle, so a stalled consumer stops new requests. While `rsp_valid` is high and `rsp_ready` is low, all result outputs hold their values.

Function codes follow the usual 3-bit load/store encoding: bits [1:0] give the size (00 byte, 01 halfword, 10 word, 11 none), and for loads bit 2 set selects zero fill. The lane offset is `req_addr_lo`: a byte access uses both bits, a halfword access uses only bit 1 (bit 0 is ignored), and a word access ignores both.

Top module: `lsu_lane_align`

## Requirements
- R1: While `rst_n` is low and after its release with no request, `rsp_valid` is 0 and `rsp_strobe` is 0000.
- R2: A request accepted on an edge (`req_valid` and `req_ready` high) gives `rsp_valid` high after that edge; `req_ready` equals `!rsp_valid || rsp_ready`; while `rsp_valid` is high and `rsp_ready` low, `rsp_strobe`, `rsp_wdata` and `rsp_ldata` stay unchanged.
- R3: `rsp_strobe` is 0000 whenever `rsp_valid` is 0 and for every load result; a load result has `rsp_wdata` 0 and a store result has `rsp_ldata` 0.
- R4: A byte store (funct3[1:0] = 00) sets only strobe bit `addr_lo`, and `rsp_wdata` is rs2 shifted left by 8*`addr_lo` bits (upper bits dropped), so rs2[7:0] lands in that lane.
- R5: A halfword store (funct3[1:0] = 01) sets strobe 0011 when `addr_lo[1]` is 0 and 1100 when it is 1, with `addr_lo[0]` ignored; `rsp_wdata` is rs2 shifted left by 16*`addr_lo[1]` bits.
- R6: A word store (funct3[1:0] = 10) sets strobe 1111 and passes rs2 unchanged, whatever `addr_lo` is.
- R7: A store with funct3[1:0] = 11 gives strobe 0000; funct3[2] has no effect on stores.
- R8: A byte load returns memory byte `addr_lo`, sign-extended for funct3 000 (0xFF gives 0xFFFFFFFF) and zero-extended for funct3 100 (0xFF gives 0x000000FF).
- R9: A halfword load returns bytes 2*`addr_lo[1]` and 2*`addr_lo[1]`+1 as a halfword, sign-extended for funct3 001 and zero-extended for funct3 101.
- R10: A word load (funct3 010) returns the memory word unchanged for every `addr_lo`.
- R11: A load with funct3 011, 110 or 111 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_store | input | 1 | 1 for a store, 0 for a load |
| req_funct3 | input | 3 | Access function code (size in [1:0], zero fill in [2] for loads) |
| req_addr_lo | input | 2 | Low address bits, the byte offset inside the word |
| req_rs2 | input | 32 | Store source data |
| req_mem_word | input | 32 | Word read from memory for a load |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result this cycle |
| rsp_strobe | output | 4 | Per-byte write enable, bit n for byte lane n |
| rsp_wdata | output | 32 | Lane-aligned store data |
| rsp_ldata | output | 32 | Extracted and extended load data |

## Verification
Loads of every function code are swept over all sixteen byte addresses of a small byte-addressed reference memory whose bytes mix 0x80, 0x7F, 0xFF and 0x01, which separates sign fill from zero fill and shows whether the right lane was picked and whether ignored address bits really are ignored. Stores of every function code and offset are run with rs2 values whose bytes all differ, so a wrong shift or a strobe in the wrong lane is visible, and the reference memory is updated from the expected strobes so the following load sweep shows the store-then-load round trip. The consumer's ready line is held low in a repeating pattern, which exercises back-pressure and the hold of a stalled result.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_NONE = 2'b11
  } acc_size_e;

  // Lowest lane touched by an access of the given size at byte offset ofs:
  // bytes use the offset as is, halfwords drop bit 0, words start at lane 0.
  function automatic logic [1:0] lane_base(acc_size_e sz, logic [1:0] ofs);
    case (sz)
      SZ_BYTE: lane_base = ofs;
      SZ_HALF: lane_base = {ofs[1], 1'b0};
      default: lane_base = 2'b00;
    endcase
  endfunction

  // Number of lanes an access of the given size covers.
  function automatic logic [2:0] lane_count(acc_size_e sz);
    case (sz)
      SZ_BYTE: lane_count = 3'd1;
      SZ_HALF: lane_count = 3'd2;
      SZ_WORD: lane_count = 3'd4;
      default: lane_count = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/store_lane_gen.sv
module store_lane_gen
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NB = DATA_W / 8,
  localparam int OW = $clog2(NB)
) (
  input  logic              en,
  input  acc_size_e         sz,
  input  logic [OW-1:0]     ofs,
  input  logic [DATA_W-1:0] src,
  output logic [NB-1:0]     strobe,
  output logic [DATA_W-1:0] data
);

  logic [OW-1:0] base;
  logic [OW:0]   first;
  logic [OW:0]   last_excl;
  logic [DATA_W-1:0] shifted;

  always_comb begin
    base      = lane_base(sz, ofs);
    first     = {1'b0, base};
    last_excl = first + lane_count(sz);
    shifted   = src << (8 * base);
  end

  for (genvar i = 0; i < NB; i++) begin : g_lane
    localparam logic [OW:0] LANE = (OW+1)'(i);
    always_comb begin
      strobe[i]        = en && (LANE >= first) && (LANE < last_excl);
      data[8*i +: 8]   = en ? shifted[8*i +: 8] : 8'h00;
    end
  end

endmodule

// File: rtl/load_lane_extract.sv
module load_lane_extract
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NB = DATA_W / 8,
  localparam int OW = $clog2(NB)
) (
  input  logic              en,
  input  logic [2:0]        funct3,
  input  logic [OW-1:0]     ofs,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] value
);

  acc_size_e         sz;
  logic              zero_fill;
  logic              legal;
  logic [DATA_W-1:0] aligned;
  logic              fill_bit;

  always_comb begin
    sz        = acc_size_e'(funct3[1:0]);
    zero_fill = funct3[2];
    legal     = en && (sz != SZ_NONE) && !(sz == SZ_WORD && zero_fill);
    aligned   = word >> (8 * lane_base(sz, ofs));
    fill_bit  = 1'b0;
    value     = '0;
    if (legal) begin
      case (sz)
        SZ_BYTE: begin
          fill_bit = !zero_fill && aligned[7];
          value    = {{(DATA_W-8){fill_bit}}, aligned[7:0]};
        end
        SZ_HALF: begin
          fill_bit = !zero_fill && aligned[15];
          value    = {{(DATA_W-16){fill_bit}}, aligned[15:0]};
        end
        default: value = aligned;
      endcase
    end
  end

endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NB = DATA_W / 8,
  localparam int OW = $clog2(NB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_store,
  input  logic [2:0]        req_funct3,
  input  logic [OW-1:0]     req_addr_lo,
  input  logic [DATA_W-1:0] req_rs2,
  input  logic [DATA_W-1:0] req_mem_word,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [NB-1:0]     rsp_strobe,
  output logic [DATA_W-1:0] rsp_wdata,
  output logic [DATA_W-1:0] rsp_ldata
);

  logic [NB-1:0]     st_strobe;
  logic [DATA_W-1:0] st_data;
  logic [DATA_W-1:0] ld_value;
  logic              take;

  store_lane_gen #(.DATA_W(DATA_W)) u_store (
    .en     (req_store),
    .sz     (acc_size_e'(req_funct3[1:0])),
    .ofs    (req_addr_lo),
    .src    (req_rs2),
    .strobe (st_strobe),
    .data   (st_data)
  );

  load_lane_extract #(.DATA_W(DATA_W)) u_load (
    .en     (!req_store),
    .funct3 (req_funct3),
    .ofs    (req_addr_lo),
    .word   (req_mem_word),
    .value  (ld_value)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_strobe <= '0;
      rsp_wdata  <= '0;
      rsp_ldata  <= '0;
    end else if (take) begin
      rsp_valid  <= 1'b1;
      rsp_strobe <= st_strobe;
      rsp_wdata  <= st_data;
      rsp_ldata  <= ld_value;
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
      rsp_strobe <= '0;
    end
  end

endmodule

// File: rtl/lsu_lane_align_chk.sv
module lsu_lane_align_chk #(
  parameter int DATA_W = 32,
  localparam int NB = DATA_W / 8,
  localparam int OW = $clog2(NB)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_store,
  input logic [2:0]        req_funct3,
  input logic [OW-1:0]     req_addr_lo,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [NB-1:0]     rsp_strobe,
  input logic [DATA_W-1:0] rsp_wdata,
  input logic [DATA_W-1:0] rsp_ldata
);

  logic acc;
  assign acc = req_valid && req_ready;

  a_r2_accept_gives_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);

  a_r2_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_strobe)
                                   && $stable(rsp_wdata) && $stable(rsp_ldata)));

  a_r3_idle_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_strobe == '0));

  a_r3_load_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_store) |=> (rsp_strobe == '0));

  a_r4_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_store && req_funct3[1:0] == 2'b00) |=> ($countones(rsp_strobe) == 1));

  a_r5_half_two_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_store && req_funct3[1:0] == 2'b01) |=> ($countones(rsp_strobe) == 2));

  a_r6_word_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_store && req_funct3[1:0] == 2'b10) |=> (&rsp_strobe));

  a_r7_none_no_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_store && req_funct3[1:0] == 2'b11) |=> (rsp_strobe == '0));

  a_r8_lbu_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_store && req_funct3 == 3'b100) |=> (rsp_ldata[DATA_W-1:8] == '0));

  a_r8_lb_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_store && req_funct3 == 3'b000)
      |=> (rsp_ldata[DATA_W-1:8] == {(DATA_W-8){rsp_ldata[7]}}));

  a_r11_illegal_load_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_store && (req_funct3 == 3'b011 || req_funct3 == 3'b110 || req_funct3 == 3'b111))
      |=> (rsp_ldata == '0));

endmodule

bind lsu_lane_align lsu_lane_align_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_store   (req_store),
  .req_funct3  (req_funct3),
  .req_addr_lo (req_addr_lo),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_strobe  (rsp_strobe),
  .rsp_wdata   (rsp_wdata),
  .rsp_ldata   (rsp_ldata)
);

// File: tb/lsu_lane_align_test.sv
module lsu_lane_align_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_store = 1'b0;
  logic [2:0]  req_funct3 = 3'b000;
  logic [1:0]  req_addr_lo = 2'b00;
  logic [31:0] req_rs2 = '0;
  logic [31:0] req_mem_word = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [3:0]  rsp_strobe;
  logic [31:0] rsp_wdata;
  logic [31:0] rsp_ldata;

  lsu_lane_align uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
    .req_funct3(req_funct3), .req_addr_lo(req_addr_lo), .req_rs2(req_rs2),
    .req_mem_word(req_mem_word),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_strobe(rsp_strobe),
    .rsp_wdata(rsp_wdata), .rsp_ldata(rsp_ldata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [3:0]  strobe;
    logic [31:0] wdata;
    logic [31:0] ldata;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  logic [7:0]  ref_mem [16];
  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 1'b0;
  bit          stall_seen = 1'b0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  // Reference model built byte by byte from the requirements.
  function automatic exp_t model(bit st, logic [2:0] f3, logic [3:0] addr, logic [31:0] rs2);
    exp_t e;
    int   base;
    int   n;
    int   w;
    logic [31:0] v;
    e.strobe = '0; e.wdata = '0; e.ldata = '0;
    w = int'(addr[3:2]);
    case (f3[1:0])
      2'b00: begin n = 1; base = int'(addr[1:0]); end
      2'b01: begin n = 2; base = addr[1] ? 2 : 0; end
      2'b10: begin n = 4; base = 0; end
      default: begin n = 0; base = 0; end
    endcase
    if (st) begin
      for (int lane = 0; lane < 4; lane++) begin
        if (lane >= base) e.wdata[8*lane +: 8] = rs2[8*(lane-base) +: 8];
        if (lane >= base && lane < base + n) e.strobe[lane] = 1'b1;
      end
      case (f3[1:0])
        2'b00: e.tag = "R4";
        2'b01: e.tag = "R5";
        2'b10: e.tag = "R6";
        default: e.tag = "R7";
      endcase
    end else begin
      if (f3 == 3'b011 || f3 == 3'b110 || f3 == 3'b111) begin
        e.ldata = '0;
        e.tag = "R11";
      end else begin
        v = '0;
        for (int k = 0; k < n; k++) v[8*k +: 8] = ref_mem[w*4 + base + k];
        if (!f3[2] && n < 4 && v[8*n-1]) begin
          for (int b = 8*n; b < 32; b++) v[b] = 1'b1;
        end
        e.ldata = v;
        e.tag = (n == 1) ? "R8" : (n == 2) ? "R9" : "R10";
      end
    end
    return e;
  endfunction

  task automatic do_req(bit st, logic [2:0] f3, logic [3:0] addr, logic [31:0] rs2);
    exp_t e;
    int   w;
    w = int'(addr[3:2]);
    e = model(st, f3, addr, rs2);
    req_valid    = 1'b1;
    req_store    = st;
    req_funct3   = f3;
    req_addr_lo  = addr[1:0];
    req_rs2      = rs2;
    req_mem_word = {ref_mem[w*4+3], ref_mem[w*4+2], ref_mem[w*4+1], ref_mem[w*4]};
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    sb_q.push_back(e);
    if (st) begin
      for (int lane = 0; lane < 4; lane++)
        if (e.strobe[lane]) ref_mem[w*4 + lane] = e.wdata[8*lane +: 8];
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  // Monitor: compares each presented result to the scoreboard head.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (rsp_valid) begin
          if (sb_q.size() == 0) begin
            n_checks++; n_fail++;
            $display("FAIL R2 unexpected result: actual valid 1 expected 0");
          end else begin
            check(sb_q[0].tag, {28'd0, rsp_strobe}, {28'd0, sb_q[0].strobe},
                  rsp_ready ? "strobe (R3)" : "strobe held in stall (R2)");
            check(sb_q[0].tag, rsp_wdata, sb_q[0].wdata, "write data (R3)");
            check(sb_q[0].tag, rsp_ldata, sb_q[0].ldata, "load data (R3)");
            if (!rsp_ready) stall_seen = 1'b1;
            if (rsp_ready) void'(sb_q.pop_front());
          end
        end else begin
          check("R3", {28'd0, rsp_strobe}, 32'd0, "idle strobe");
        end
      end
    end
  end

  // Consumer back-pressure pattern.
  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      rsp_ready = (cyc % 7 != 3) && (cyc % 11 != 5);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      case (i % 4)
        0: ref_mem[i] = 8'h80;
        1: ref_mem[i] = 8'h7F;
        2: ref_mem[i] = 8'hFF;
        default: ref_mem[i] = 8'h01;
      endcase
      if (i >= 8) ref_mem[i] = ref_mem[i] ^ 8'h7E;
    end
    repeat (3) @(posedge clk);
    #1;
    check("R1", {31'd0, rsp_valid}, 32'd0, "valid in reset");
    check("R1", {28'd0, rsp_strobe}, 32'd0, "strobe in reset");
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", {31'd0, rsp_valid}, 32'd0, "valid after reset");
    check("R2", {31'd0, req_ready}, 32'd1, "ready when empty");

    // Load sweep over every code and address.
    for (int f = 0; f < 8; f++)
      for (int a = 0; a < 16; a++)
        do_req(1'b0, 3'(f), 4'(a), 32'h0);

    // Store sweep over every code and offset, with distinct byte values.
    for (int f = 0; f < 8; f++)
      for (int a = 0; a < 16; a++)
        do_req(1'b1, 3'(f), 4'(a), 32'hC3A5_1000 | 32'(f * 16 + a));

    // Round-trip loads after the stores.
    for (int f = 0; f < 8; f++)
      for (int a = 0; a < 16; a++)
        do_req(1'b0, 3'(f), 4'(a), 32'h0);

    // Back-to-back stream of mixed requests.
    for (int a = 0; a < 16; a++) begin
      do_req(1'b1, 3'b000, 4'(a), 32'h0000_00FF);
      do_req(1'b0, 3'b000, 4'(a), 32'h0);
      do_req(1'b0, 3'b100, 4'(a), 32'h0);
    end

    for (int t = 0; t < 200 && sb_q.size() != 0; t++) @(posedge clk);
    #1;
    check("R2", 32'(sb_q.size()), 32'd0, "results drained");
    check("R2", {31'd0, stall_seen}, 32'd1, "stall exercised");
    finish_run();
  end

endmodule